// File: doc/BRIEF.md
# Fractional Microsecond Timebase

This block turns a reference clock whose rate need not be a whole number of megahertz into a steady one-microsecond tick enable. It also keeps a free-running microsecond count. The rate is set by a rational ratio held in a 16-bit ratio register. That register has two one-byte fields, each stored as its value minus one. The low byte, P, sets the number of reference clocks in one window, which is P+1. The high byte, Q, sets the number of ticks emitted over that window, which is Q+1. A ratio of 64/5 therefore gives an exact 1 MHz average from a 12.8 MHz reference, and 12/1 gives one tick every twelfth clock from 12 MHz.

Internally, a phase accumulator adds Q+1 on every reference clock. Whenever the sum reaches P+1, it subtracts P+1 and raises the tick for one cycle. As a result, the block emits at most one tick per clock. A hold register stops both the accumulator and the counter. Software reaches the count, the ratio and the hold bit through a simple word-wide register port with one cycle of read latency.

Top module: `usec_timebase`

## Requirements
- R1: While reset is asserted and just after it, the count is 0 and the tick is low. The ratio register holds 0x000B (P=11, Q=0) and the hold bit is 0.
- R2: Start with the accumulator cleared, Q not greater than P, and hold off. After k clocks, exactly floor(k*(Q+1)/(P+1)) ticks have been emitted. The tick is high for at most one cycle per clock edge.
- R3: When Q is greater than P, the tick is high on every clock while hold is off.
- R4: The count rises by exactly one on the same edge that raises the tick, and stays put otherwise. It wraps to 0 after 2^COUNT_W - 1.
- R5: Writing 1 to bit 0 of offset 0x4C sets hold. While hold is set, the accumulator and the count keep their values and the tick stays low. The edge that writes the hold bit still acts on the old hold value.
- R6: A write to offset 0x14 loads P from data bits 7:0 and Q from bits 15:8, and clears the accumulator. On that edge no tick is emitted, even where one was due, and the count is left as it was.
- R7: A read returns its data on the edge after the address is presented. Offset 0x10 returns the count, 0x14 returns the ratio register zero-extended, 0x4C returns the hold bit in bit 0, and any other offset returns 0.
- R8: Writes to offset 0x10 or to any unmapped offset change neither the count, the ratio register nor the hold bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered, one cycle after the address |
| tick_o | output | 1 | One-cycle microsecond tick enable |
| count_o | output | COUNT_W | Free-running microsecond count |

## Verification
A ratio write and a due tick can fall on the same edge. The bench provokes this by rewriting the ratio register exactly on the clock where the accumulator would cross its limit. It then judges that the tick stays low, the count stays put, and the next tick arrives a full window of P+1 clocks later. A hold write and a pending tick are raced the same way: the hold edge itself still counts, and the clock after release resumes from the held phase, so the tick lands on the twelfth clock that is not held.

// File: rtl/usec_pkg.sv
package usec_pkg;

  localparam int unsigned OFS_COUNT = 32'h10;
  localparam int unsigned OFS_RATIO = 32'h14;
  localparam int unsigned OFS_HOLD  = 32'h4C;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_RATIO = 2'd2,
    SEL_HOLD  = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input int unsigned ofs);
    case (ofs)
      OFS_COUNT: return SEL_COUNT;
      OFS_RATIO: return SEL_RATIO;
      OFS_HOLD:  return SEL_HOLD;
      default:   return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/usec_cfg_regs.sv
module usec_cfg_regs
  import usec_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned FIELD_W   = 8,
  parameter logic [2*FIELD_W-1:0] RATIO_RST = 16'h000B
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  reg_sel_e               sel,
  input  logic [DATA_W-1:0]      wdata,
  output logic [2*FIELD_W-1:0]   ratio_q,
  output logic                   hold_q,
  output logic                   ratio_wr
);

  localparam int unsigned RATIO_W = 2 * FIELD_W;

  logic hold_wr;
  logic unused_wdata_hi;

  assign ratio_wr = wr && (sel == SEL_RATIO);
  assign hold_wr  = wr && (sel == SEL_HOLD);
  assign unused_wdata_hi = ^wdata[DATA_W-1:RATIO_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= RATIO_RST;
      hold_q  <= 1'b0;
    end else begin
      if (ratio_wr) ratio_q <= wdata[RATIO_W-1:0];
      if (hold_wr)  hold_q  <= wdata[0];
    end
  end

endmodule

// File: rtl/usec_frac_accum.sv
module usec_frac_accum #(
  parameter int unsigned FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] period_m1,
  input  logic [FIELD_W-1:0] ticks_m1,
  input  logic               clr,
  input  logic               hold,
  output logic               tick_nxt,
  output logic               tick_q
);

  localparam int unsigned ACC_W = FIELD_W + 1;
  localparam int unsigned SUM_W = FIELD_W + 2;

  logic [ACC_W-1:0] acc_q, acc_nxt;
  logic [SUM_W-1:0] sum, lim;
  logic             saturate;

  assign sum      = SUM_W'(acc_q) + SUM_W'(ticks_m1) + SUM_W'(1);
  assign lim      = SUM_W'(period_m1) + SUM_W'(1);
  assign saturate = ticks_m1 > period_m1;

  always_comb begin
    acc_nxt  = acc_q;
    tick_nxt = 1'b0;
    if (clr) begin
      acc_nxt = '0;
    end else if (!hold) begin
      if (saturate) begin
        acc_nxt  = '0;
        tick_nxt = 1'b1;
      end else if (sum >= lim) begin
        acc_nxt  = ACC_W'(sum - lim);
        tick_nxt = 1'b1;
      end else begin
        acc_nxt = ACC_W'(sum);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_nxt;
      tick_q <= tick_nxt;
    end
  end

endmodule

// File: rtl/usec_count.sv
module usec_count #(
  parameter int unsigned COUNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inc,
  output logic [COUNT_W-1:0] count_q
);

  always_ff @(posedge clk) begin
    if (rst)      count_q <= '0;
    else if (inc) count_q <= count_q + COUNT_W'(1);
  end

endmodule

// File: rtl/usec_timebase.sv
module usec_timebase
  import usec_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned FIELD_W   = 8,
  parameter int unsigned COUNT_W   = 32,
  parameter logic [2*FIELD_W-1:0] RATIO_RST = 16'h000B
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               tick_o,
  output logic [COUNT_W-1:0] count_o
);

  localparam int unsigned RATIO_W = 2 * FIELD_W;

  reg_sel_e           sel;
  logic [RATIO_W-1:0] ratio_q;
  logic               hold_q;
  logic               ratio_wr;
  logic               tick_nxt;
  logic [COUNT_W-1:0] count_q;

  assign sel = decode_ofs(int'(reg_addr));

  usec_cfg_regs #(
    .DATA_W(DATA_W), .FIELD_W(FIELD_W), .RATIO_RST(RATIO_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(sel), .wdata(reg_wdata),
    .ratio_q(ratio_q), .hold_q(hold_q), .ratio_wr(ratio_wr)
  );

  usec_frac_accum #(.FIELD_W(FIELD_W)) u_accum (
    .clk(clk), .rst(rst),
    .period_m1(ratio_q[FIELD_W-1:0]),
    .ticks_m1(ratio_q[RATIO_W-1:FIELD_W]),
    .clr(ratio_wr), .hold(hold_q),
    .tick_nxt(tick_nxt), .tick_q(tick_o)
  );

  usec_count #(.COUNT_W(COUNT_W)) u_count (
    .clk(clk), .rst(rst), .inc(tick_nxt), .count_q(count_q)
  );

  assign count_o = count_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (sel)
        SEL_COUNT: reg_rdata <= DATA_W'(count_q);
        SEL_RATIO: reg_rdata <= DATA_W'(ratio_q);
        SEL_HOLD:  reg_rdata <= DATA_W'(hold_q);
        default:   reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/usec_timebase_chk.sv
module usec_timebase_chk #(
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned COUNT_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 tick,
  input logic [COUNT_W-1:0]   count,
  input logic                 hold,
  input logic                 ratio_wr,
  input logic [2*FIELD_W-1:0] ratio
);

  a_r1_reset_state: assert property (@(posedge clk)
    $fell(rst) |-> (count == '0) && !tick);

  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tick ? (count == $past(count) + COUNT_W'(1)) : $stable(count)));

  a_r5_hold_freezes: assert property (@(posedge clk) disable iff (rst)
    hold |=> !tick && $stable(count));

  a_r6_ratio_write_clears: assert property (@(posedge clk) disable iff (rst)
    ratio_wr |=> !tick && $stable(count));

  a_r3_saturate: assert property (@(posedge clk) disable iff (rst)
    (!hold && !ratio_wr && (ratio[2*FIELD_W-1:FIELD_W] > ratio[FIELD_W-1:0])) |=> tick);

endmodule

bind usec_timebase usec_timebase_chk #(.FIELD_W(FIELD_W), .COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_o), .count(count_o),
  .hold(hold_q), .ratio_wr(ratio_wr), .ratio(ratio_q)
);

// File: tb/test_usec_timebase.sv
module test_usec_timebase;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_COUNT = 8'h10;
  localparam logic [ADDR_W-1:0] A_RATIO = 8'h14;
  localparam logic [ADDR_W-1:0] A_HOLD  = 8'h4C;
  localparam logic [ADDR_W-1:0] A_NONE  = 8'h20;

  // {ratio value, clocks to run}
  localparam int NVEC = 11;
  localparam logic [47:0] VEC [NVEC] = '{
    {16'h000B, 32'd120},
    {16'h043F, 32'd640},
    {16'h0453, 32'd840},
    {16'h045F, 32'd960},
    {16'h04BF, 32'd1920},
    {16'h000C, 32'd130},
    {16'h0019, 32'd26},
    {16'h002F, 32'd100},
    {16'h043F, 32'd63},
    {16'h0000, 32'd10},
    {16'h0100, 32'd10}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata, rdata_s;
  logic              tick_o, tick_s;
  logic [31:0]       count_o;
  logic [7:0]        count_s;

  int total = 0;
  int bad = 0;
  int ticks_seen = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  usec_timebase i_usec_timebase (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_o(tick_o), .count_o(count_o)
  );

  usec_timebase #(.COUNT_W(8)) i_small (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_s),
    .tick_o(tick_s), .count_o(count_s)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (tick_o) ticks_seen++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    logic [7:0]  cs0;
    logic [7:0]  pa, qb;
    int n, expd;

    repeat (3) @(negedge clk);
    check("R1 count in reset", count_o, 0);
    check("R1 tick in reset", {31'd0, tick_o}, 0);
    rst = 1'b0;
    rd(A_RATIO, v); check("R1 ratio reset value", v, 32'h000B);
    rd(A_HOLD, v);  check("R1 hold reset value", v, 0);

    // R2 R3 R4: ratio table
    for (int i = 0; i < NVEC; i++) begin
      n  = int'(VEC[i][31:0]);
      pa = VEC[i][39:32];
      qb = VEC[i][47:40];
      expd = (qb > pa) ? n : (n * (int'(qb) + 1)) / (int'(pa) + 1);
      wr(A_RATIO, 32'(VEC[i][47:32]));
      c0 = count_o;
      ticks_seen = 0;
      run(n);
      check((qb > pa) ? "R3 saturated tick count" : "R2 ratio count delta", count_o - c0, 32'(expd));
      check("R4 ticks match count steps", 32'(ticks_seen), 32'(expd));
    end

    // R5: hold keeps phase and count
    wr(A_RATIO, 32'h000B);
    c0 = count_o;
    run(5);
    wr(A_HOLD, 32'h1);
    check("R5 no tick on hold edge", count_o, c0);
    ticks_seen = 0;
    run(20);
    check("R5 count held", count_o, c0);
    check("R5 tick low while held", 32'(ticks_seen), 0);
    rd(A_COUNT, v); check("R7 count readback", v, c0);
    rd(A_HOLD, v);  check("R7 hold readback", v, 1);
    // R8: ignored writes
    wr(A_COUNT, 32'h1234_5678);
    wr(A_NONE, 32'hFFFF_FFFF);
    check("R8 count untouched", count_o, c0);
    rd(A_RATIO, v); check("R8 ratio untouched", v, 32'h000B);
    rd(A_NONE, v);  check("R7 unmapped reads zero", v, 0);
    rd(A_HOLD, v);  check("R8 hold untouched", v, 1);
    wr(A_HOLD, 32'h0);
    run(5);
    check("R5 resume keeps phase (before)", count_o, c0);
    run(1);
    check("R5 resume keeps phase (tick)", count_o, c0 + 1);
    check("R5 tick on twelfth free clock", {31'd0, tick_o}, 1);

    // R6: ratio write races a due tick
    wr(A_RATIO, 32'hABCD_000B);
    rd(A_RATIO, v); check("R6 upper data bits dropped", v, 32'h000B);
    wr(A_RATIO, 32'h000B);
    c0 = count_o;
    run(11);
    check("R6 no tick before limit", count_o, c0);
    wr(A_RATIO, 32'h000B);
    check("R6 write beats due tick", count_o, c0);
    check("R6 tick low on write edge", {31'd0, tick_o}, 0);
    run(11);
    check("R6 accumulator cleared", count_o, c0);
    run(1);
    check("R6 tick after full window", count_o, c0 + 1);

    // R4: wrap on the narrow instance
    wr(A_RATIO, 32'h0000);
    c0 = count_o; cs0 = count_s;
    run(300);
    check("R4 wide count", count_o, c0 + 300);
    check("R4 narrow count wraps", {24'd0, count_s}, {24'd0, 8'(cs0 + 8'd44)});

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule